// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block lets an external two-wire bus master program and read back a bank of byte-wide configuration registers. It watches the sampled clock and data lines of the bus, recognises bus conditions and its own two fixed device address bytes, and acknowledges bytes by pulling the data line low through an open-drain enable. Addressing follows the habits of small serial memories. A write transfer carries a register address and then any number of data bytes. A read transfer returns bytes from the internal pointer. A random read is a pointer write, then a repeated start and a read.

The block answers only when a two-bit mode strap selects slave operation. Register 1, bit 0 acts as a run flag. Software can set it but cannot clear it, and its value is brought out as a port. The register file holds 128 bytes. Addresses 128 to 255 are acknowledged but hold nothing.

Top module: `serial_cfg_slave`

## Requirements
- R1: The block acknowledges nothing and never drives the data line unless `mode_strap` equals 2'b01.
- R2: Address byte 8'hBE opens a write and 8'hBF opens a read, each acknowledged by driving SDA low in the ninth clock slot. Any other address byte leaves SDA released in that slot.
- R3: In a write, the first byte after the address is the register pointer. Each following data byte is stored at the pointer and acknowledged, and the pointer then increments by one.
- R4: A read returns the byte at the current pointer, MSB first, and increments the pointer after each byte. A master ACK asks for the next byte, and a master NACK ends the transfer with SDA released.
- R5: All registers read 0x00 after reset, and a read returns the last value written to that register.
- R6: Register 1, bit 0 reads 0 after reset, becomes 1 when written with 1, and its value appears on `start_o`.
- R7: Once register 1, bit 0 is 1, writing 0 to it has no effect until reset. The other seven bits of register 1 behave as ordinary storage.
- R8: Pointer values 128 to 255 are acknowledged. Writes there are discarded and reads return 0x00.
- R9: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A START or STOP inside a byte aborts the transfer, and the partial byte is not written.
- R10: SDA is only ever pulled low, through `sda_oe`. The drive is released after a STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_strap | input | 2 | Mode strap; 2'b01 enables the slave |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| start_o | output | 1 | Current value of the write-once run flag |

## Verification
Bus lines pass two synchroniser flops and one edge-detect flop. The slave therefore changes `sda_oe` about three system cycles after it sees an SCL edge. The bench holds each quarter of a bus bit for eight cycles. It changes SDA only in the middle of SCL low and samples SDA a full quarter after SCL rises, so every acknowledge and data bit has settled by the time it is read. Register contents and the run flag are checked only after a STOP has closed the transfer, which is many cycles after the single-cycle register write.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_RX,
      PH_RXACK,
      PH_TX,
      PH_TXACK
   } phase_e;

   typedef enum logic [1:0] {
      RX_DEV,
      RX_PTR,
      RX_DATA
   } rxkind_e;

   typedef struct packed {
      logic start;
      logic stop;
      logic rise;
      logic fall;
      logic sda;
   } line_ev_t;

endpackage

// File: rtl/i2cs_line_sync.sv
module i2cs_line_sync
   import i2cs_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     scl_in,
   input  logic     sda_in,
   output line_ev_t ev
);

   localparam int MSB = SYNC_STAGES - 1;

   generate
      if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_depth
         $error("i2cs_line_sync: SYNC_STAGES must be 2..4");
      end
   endgenerate

   logic [MSB:0] scl_sh, sda_sh;
   logic         scl_d, sda_d;
   logic         scl_c, sda_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[MSB-1:0], scl_in};
         sda_sh <= {sda_sh[MSB-1:0], sda_in};
         scl_d  <= scl_sh[MSB];
         sda_d  <= sda_sh[MSB];
      end
   end

   assign scl_c = scl_sh[MSB];
   assign sda_c = sda_sh[MSB];

   always_comb begin
      ev.start = scl_c & scl_d & sda_d & ~sda_c;
      ev.stop  = scl_c & scl_d & ~sda_d & sda_c;
      ev.rise  = scl_c & ~scl_d;
      ev.fall  = ~scl_c & scl_d;
      ev.sda   = sda_c;
   end

endmodule

// File: rtl/i2cs_regfile.sv
module i2cs_regfile #(
   parameter int REG_COUNT  = 128,
   parameter int STICKY_REG = 1,
   parameter int STICKY_BIT = 0,
   parameter bit STICKY_EN  = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       we,
   input  logic [7:0] addr,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       sticky_o
);

   localparam int               IDX_W       = $clog2(REG_COUNT);
   localparam logic [8:0]       LIMIT       = 9'(REG_COUNT);
   localparam logic [7:0]       STICKY_ADDR = 8'(STICKY_REG);
   localparam logic [IDX_W-1:0] SIDX        = IDX_W'(STICKY_REG);

   generate
      if (REG_COUNT < 2 || REG_COUNT > 256 || (REG_COUNT & (REG_COUNT - 1)) != 0) begin : g_bad_count
         $error("i2cs_regfile: REG_COUNT must be a power of two in 2..256");
      end
      if (STICKY_REG >= REG_COUNT || STICKY_BIT > 7) begin : g_bad_sticky
         $error("i2cs_regfile: sticky location outside the register file");
      end
   endgenerate

   logic [7:0] mem [REG_COUNT];
   logic       in_range;
   logic [7:0] merged;

   assign in_range = ({1'b0, addr} < LIMIT);

   generate
      if (STICKY_EN) begin : g_sticky
         always_comb begin
            merged = wdata;
            if (addr == STICKY_ADDR)
               merged[STICKY_BIT] = wdata[STICKY_BIT] | mem[SIDX][STICKY_BIT];
         end

         // R7: once set, the run flag stays set until reset
         a_r7_start_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            sticky_o |=> sticky_o);
      end else begin : g_plain
         assign merged = wdata;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < REG_COUNT; i++) mem[i] <= '0;
      end else if (we && in_range) begin
         mem[addr[IDX_W-1:0]] <= merged;
      end
   end

   assign rdata    = in_range ? mem[addr[IDX_W-1:0]] : 8'h00;
   assign sticky_o = mem[SIDX][STICKY_BIT];

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
   import i2cs_pkg::*;
#(
   parameter logic [7:0] DEV_WR = 8'hBE,
   parameter logic [7:0] DEV_RD = 8'hBF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       en,
   input  line_ev_t   ev,
   output logic       sda_oe,
   output logic       reg_we,
   output logic [7:0] reg_addr,
   output logic [7:0] reg_wdata,
   input  logic [7:0] reg_rdata
);

   generate
      if (DEV_WR == DEV_RD) begin : g_bad_dev
         $error("i2cs_engine: read and write address bytes must differ");
      end
   endgenerate

   phase_e     phase_q;
   rxkind_e    kind_q;
   logic       rd_q;
   logic       mack_q;
   logic       oe_q;
   logic [3:0] cnt_q;
   logic [7:0] shreg_q;
   logic [7:0] ptr_q;
   logic       byte_done;

   assign byte_done = (phase_q == PH_RX) && ev.fall && (cnt_q == 4'd8);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         kind_q  <= RX_DEV;
         rd_q    <= 1'b0;
         mack_q  <= 1'b0;
         oe_q    <= 1'b0;
         cnt_q   <= '0;
         shreg_q <= '0;
         ptr_q   <= '0;
      end else if (!en) begin
         phase_q <= PH_IDLE;
         oe_q    <= 1'b0;
      end else if (ev.stop) begin
         phase_q <= PH_IDLE;
         oe_q    <= 1'b0;
      end else if (ev.start) begin
         phase_q <= PH_RX;
         kind_q  <= RX_DEV;
         cnt_q   <= '0;
         oe_q    <= 1'b0;
      end else begin
         unique case (phase_q)
            PH_RX: begin
               if (ev.rise) begin
                  shreg_q <= {shreg_q[6:0], ev.sda};
                  cnt_q   <= cnt_q + 4'd1;
               end else if (byte_done) begin
                  cnt_q <= '0;
                  unique case (kind_q)
                     RX_DEV: begin
                        if (shreg_q == DEV_WR) begin
                           rd_q    <= 1'b0;
                           kind_q  <= RX_PTR;
                           oe_q    <= 1'b1;
                           phase_q <= PH_RXACK;
                        end else if (shreg_q == DEV_RD) begin
                           rd_q    <= 1'b1;
                           oe_q    <= 1'b1;
                           phase_q <= PH_RXACK;
                        end else begin
                           phase_q <= PH_IDLE;
                        end
                     end
                     RX_PTR: begin
                        ptr_q   <= shreg_q;
                        kind_q  <= RX_DATA;
                        oe_q    <= 1'b1;
                        phase_q <= PH_RXACK;
                     end
                     RX_DATA: begin
                        ptr_q   <= ptr_q + 8'd1;
                        oe_q    <= 1'b1;
                        phase_q <= PH_RXACK;
                     end
                     default: phase_q <= PH_IDLE;
                  endcase
               end
            end
            PH_RXACK: begin
               if (ev.fall) begin
                  cnt_q <= '0;
                  if (rd_q) begin
                     shreg_q <= reg_rdata;
                     oe_q    <= ~reg_rdata[7];
                     phase_q <= PH_TX;
                  end else begin
                     oe_q    <= 1'b0;
                     phase_q <= PH_RX;
                  end
               end
            end
            PH_TX: begin
               if (ev.fall) begin
                  if (cnt_q == 4'd7) begin
                     oe_q    <= 1'b0;
                     ptr_q   <= ptr_q + 8'd1;
                     phase_q <= PH_TXACK;
                  end else begin
                     cnt_q   <= cnt_q + 4'd1;
                     shreg_q <= {shreg_q[6:0], 1'b0};
                     oe_q    <= ~shreg_q[6];
                  end
               end
            end
            PH_TXACK: begin
               if (ev.rise) begin
                  mack_q <= ~ev.sda;
               end else if (ev.fall) begin
                  if (mack_q) begin
                     shreg_q <= reg_rdata;
                     oe_q    <= ~reg_rdata[7];
                     cnt_q   <= '0;
                     phase_q <= PH_TX;
                  end else begin
                     phase_q <= PH_IDLE;
                  end
               end
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign sda_oe    = oe_q;
   assign reg_addr  = ptr_q;
   assign reg_wdata = shreg_q;
   assign reg_we    = en && !ev.start && !ev.stop && byte_done && (kind_q == RX_DATA);

   // R1: a disabled slave goes idle and releases the line
   a_r1_idle_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (!sda_oe && phase_q == PH_IDLE));

   // R10: the line is released after a STOP
   a_r10_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ev.stop) |=> !sda_oe);

   // R2: an address acknowledge only follows a matching address byte
   a_r2_ack_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(oe_q) && $past(phase_q) == PH_RX && $past(kind_q) == RX_DEV)
      |-> ($past(shreg_q) == DEV_WR || $past(shreg_q) == DEV_RD));

   // R4: the pointer steps by one after each byte sent
   a_r4_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !ev.start && !ev.stop && phase_q == PH_TX && ev.fall && cnt_q == 4'd7)
      |=> ptr_q == $past(ptr_q) + 8'd1);

endmodule

// File: rtl/serial_cfg_slave.sv
module serial_cfg_slave
   import i2cs_pkg::*;
#(
   parameter int         REG_COUNT   = 128,
   parameter logic [7:0] DEV_WR      = 8'hBE,
   parameter logic [7:0] DEV_RD      = 8'hBF,
   parameter logic [1:0] MODE_SEL    = 2'b01,
   parameter int         SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] mode_strap,
   input  logic       scl_in,
   input  logic       sda_in,
   output logic       sda_oe,
   output logic       start_o
);

   line_ev_t   ev;
   logic       en;
   logic       reg_we;
   logic [7:0] reg_addr;
   logic [7:0] reg_wdata;
   logic [7:0] reg_rdata;

   assign en = (mode_strap == MODE_SEL);

   i2cs_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_in (scl_in),
      .sda_in (sda_in),
      .ev     (ev)
   );

   i2cs_engine #(.DEV_WR(DEV_WR), .DEV_RD(DEV_RD)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .ev        (ev),
      .sda_oe    (sda_oe),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata)
   );

   i2cs_regfile #(
      .REG_COUNT  (REG_COUNT),
      .STICKY_REG (1),
      .STICKY_BIT (0),
      .STICKY_EN  (1'b1)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .rdata    (reg_rdata),
      .sticky_o (start_o)
   );

endmodule

// File: tb/serial_cfg_slave_bench.sv
`timescale 1ns/1ps
module serial_cfg_slave_bench;

   localparam int Q = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mode_strap = 2'b01;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       sda_oe;
   logic       start_o;
   wire        sda_line = sda_m & ~sda_oe;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   serial_cfg_slave u_serial_cfg_slave (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode_strap (mode_strap),
      .scl_in     (scl_m),
      .sda_in     (sda_line),
      .sda_oe     (sda_oe),
      .start_o    (start_o)
   );

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic w();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; w(); scl_m = 1'b1; w(); sda_m = 1'b0; w(); scl_m = 1'b0; w();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; w(); scl_m = 1'b1; w(); sda_m = 1'b1; w();
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; w(); scl_m = 1'b1; w(); w(); scl_m = 1'b0; w();
   endtask

   task automatic put_byte(input logic [7:0] d, output logic acked);
      for (int i = 7; i >= 0; i--) put_bit(d[i]);
      sda_m = 1'b1; w(); scl_m = 1'b1; w();
      acked = !sda_line;
      w(); scl_m = 1'b0; w();
   endtask

   task automatic get_byte(output logic [7:0] d, input logic mack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; w(); scl_m = 1'b1; w();
         d[i] = sda_line;
         w(); scl_m = 1'b0; w();
      end
      sda_m = ~mack; w(); scl_m = 1'b1; w(); w(); scl_m = 1'b0; w();
      sda_m = 1'b1;
   endtask

   task automatic write_reg(input logic [7:0] a, input logic [7:0] d, output logic all_ack);
      logic k1, k2, k3;
      bus_start();
      put_byte(8'hBE, k1);
      put_byte(a, k2);
      put_byte(d, k3);
      bus_stop();
      all_ack = k1 & k2 & k3;
   endtask

   task automatic read_at(input logic [7:0] a, output logic [7:0] d, output logic all_ack);
      logic k1, k2, k3;
      bus_start();
      put_byte(8'hBE, k1);
      put_byte(a, k2);
      bus_start();
      put_byte(8'hBF, k3);
      get_byte(d, 1'b0);
      bus_stop();
      all_ack = k1 & k2 & k3;
   endtask

   task automatic t_reset();
      logic [7:0] d; logic k;
      chk(sda_oe == 1'b0, "R10 line released after reset", 16'(sda_oe), 16'h0);
      chk(start_o == 1'b0, "R6 run flag clear after reset", 16'(start_o), 16'h0);
      read_at(8'h05, d, k);
      chk(k, "R2 acks on random read", 16'(k), 16'h1);
      chk(d == 8'h00, "R5 register zero after reset", 16'(d), 16'h00);
   endtask

   task automatic t_single();
      logic [7:0] d; logic k;
      write_reg(8'h05, 8'hA5, k);
      chk(k, "R3 single write acked", 16'(k), 16'h1);
      read_at(8'h05, d, k);
      chk(d == 8'hA5, "R5 single readback", 16'(d), 16'hA5);
      chk(sda_oe == 1'b0, "R10 released after stop", 16'(sda_oe), 16'h0);
   endtask

   task automatic t_burst();
      logic [7:0] vals [5];
      logic [7:0] d; logic k, kk;
      vals = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
      bus_start();
      put_byte(8'hBE, k); kk = k;
      put_byte(8'h20, k); kk &= k;
      for (int i = 0; i < 5; i++) begin put_byte(vals[i], k); kk &= k; end
      bus_stop();
      chk(kk, "R3 burst write acked", 16'(kk), 16'h1);
      bus_start();
      put_byte(8'hBE, k);
      put_byte(8'h20, k);
      bus_start();
      put_byte(8'hBF, k);
      for (int i = 0; i < 4; i++) begin
         get_byte(d, i != 3);
         chk(d == vals[i], "R3 R4 sequential read data", 16'(d), 16'(vals[i]));
      end
      bus_stop();
      bus_start();
      put_byte(8'hBF, k);
      get_byte(d, 1'b0);
      bus_stop();
      chk(d == 8'h55, "R4 current-pointer read continues", 16'(d), 16'h55);
   endtask

   task automatic t_badaddr();
      logic k;
      bus_start();
      put_byte(8'hA0, k);
      bus_stop();
      chk(!k, "R2 foreign address not acked", 16'(k), 16'h0);
      bus_start();
      put_byte(8'hBC, k);
      bus_stop();
      chk(!k, "R2 near-miss address not acked", 16'(k), 16'h0);
      bus_start();
      put_byte(8'hBF, k);
      chk(k, "R2 read address acked", 16'(k), 16'h1);
      begin logic [7:0] d; get_byte(d, 1'b0); end
      bus_stop();
   endtask

   task automatic t_run_flag();
      logic [7:0] d; logic k;
      write_reg(8'h01, 8'h00, k);
      chk(start_o == 1'b0, "R6 writing 0 keeps flag clear", 16'(start_o), 16'h0);
      write_reg(8'h01, 8'h81, k);
      chk(start_o == 1'b1, "R6 writing 1 sets flag", 16'(start_o), 16'h1);
      read_at(8'h01, d, k);
      chk(d == 8'h81, "R6 readback of register 1", 16'(d), 16'h81);
      write_reg(8'h01, 8'h40, k);
      chk(start_o == 1'b1, "R7 flag ignores write of 0", 16'(start_o), 16'h1);
      read_at(8'h01, d, k);
      chk(d == 8'h41, "R7 other bits ordinary, bit0 held", 16'(d), 16'h41);
   endtask

   task automatic t_high();
      logic [7:0] d; logic k, k1, k2;
      write_reg(8'h90, 8'h5A, k);
      chk(k, "R8 high address write acked", 16'(k), 16'h1);
      read_at(8'h90, d, k);
      chk(k, "R8 high address read acked", 16'(k), 16'h1);
      chk(d == 8'h00, "R8 high address reads zero", 16'(d), 16'h00);
      bus_start();
      put_byte(8'hBE, k);
      put_byte(8'h7F, k);
      put_byte(8'h3C, k1);
      put_byte(8'h77, k2);
      bus_stop();
      chk(k1 & k2, "R8 write across 127/128 acked", 16'({k1, k2}), 16'h3);
      read_at(8'h7F, d, k);
      chk(d == 8'h3C, "R3 last register stored", 16'(d), 16'h3C);
      read_at(8'h80, d, k);
      chk(d == 8'h00, "R8 write past 127 discarded", 16'(d), 16'h00);
   endtask

   task automatic t_abort();
      logic [7:0] d; logic k;
      write_reg(8'h10, 8'h66, k);
      bus_start();
      put_byte(8'hBE, k);
      put_byte(8'h10, k);
      put_bit(1'b0); put_bit(1'b0); put_bit(1'b0);
      bus_stop();
      read_at(8'h10, d, k);
      chk(d == 8'h66, "R9 stop mid-byte writes nothing", 16'(d), 16'h66);
      bus_start();
      put_byte(8'hBE, k);
      put_byte(8'h10, k);
      put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
      bus_start();
      put_byte(8'hBF, k);
      chk(k, "R9 repeated start mid-byte restarts", 16'(k), 16'h1);
      get_byte(d, 1'b0);
      bus_stop();
      chk(d == 8'h66, "R9 aborted byte not written", 16'(d), 16'h66);
   endtask

   task automatic t_mode();
      logic [7:0] d; logic k;
      mode_strap = 2'b00; w();
      bus_start(); put_byte(8'hBE, k); bus_stop();
      chk(!k, "R1 strap 00 not acked", 16'(k), 16'h0);
      mode_strap = 2'b10; w();
      bus_start(); put_byte(8'hBE, k); put_byte(8'h05, k); put_byte(8'h99, k); bus_stop();
      chk(!k, "R1 strap 10 not acked", 16'(k), 16'h0);
      mode_strap = 2'b01; w();
      read_at(8'h05, d, k);
      chk(d == 8'hA5, "R1 write while disabled ignored", 16'(d), 16'hA5);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_reset();
      t_single();
      t_burst();
      t_badaddr();
      t_run_flag();
      t_high();
      t_abort();
      t_mode();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule